// File: doc/BRIEF.md
# SPI Minion with Ready/Valid Flow-Control Header

This block is a full-duplex SPI minion that exchanges fixed 20-bit frames with an external host. The upper two bits of each frame form a header. The remaining 18 bits are a payload, which the block passes through unchanged: a destination select at bit 17, a 5-bit register address in bits 16:12, and a 12-bit value in bits 11:0. In the frame the host shifts in, the header is a command: 00 none, 01 read, 10 write, 11 write and read. In the frame the minion shifts back, the header carries two flags. Bit 19 says the receive queue has space. Bit 18 says the returned payload is a valid outgoing message.

The SPI pins are sampled into the core clock through a synchroniser chain. A frame engine runs as a three-state machine. ST_IDLE waits for chip select to fall. On that edge it snapshots both queue flags and the transmit queue head, loads the reply shift register, and moves to ST_SHIFT. ST_SHIFT counts clocks and shifts bits in both directions. When chip select rises, ST_SHIFT moves to ST_COMMIT if exactly 20 clocks were seen, and back to ST_IDLE otherwise. ST_COMMIT lasts one cycle. It pushes a written payload into the receive queue and pops the transmit queue on a read, then returns to ST_IDLE.

On the core side there are two streams. Received payloads leave on a ready/valid output stream. Outgoing payloads enter on a ready/valid input stream.

Top module: `spi_rv_minion`

## Requirements
- R1: After reset, rx_valid is 0, tx_ready is 1 and miso is 0.
- R2: Frames use SPI mode 0 and are MSB first. mosi is sampled on rising sclk edges, and miso changes only after falling sclk edges while cs_n is low.
- R3: Reply bit 19 is 1 exactly when the receive queue was not full at the falling edge of cs_n that opened the frame.
- R4: Reply bit 18 is 1 exactly when the transmit queue was non-empty at the falling edge of cs_n. The reply bits 17:0 are then the queue head; otherwise they are all zero.
- R5: A complete frame whose command is 10 or 11 appends its 18-bit payload, unchanged, to the receive queue. The rx stream delivers payloads in arrival order.
- R6: A complete frame whose command is 01 or 11 removes exactly one transmit entry, but only if an entry was present at the frame start. Commands 00 and 10 remove nothing.
- R7: A write that reaches a full receive queue is discarded. The entries already queued are delivered intact.
- R8: A frame that ends with a clock count other than 20 causes no push and no pop.
- R9: tx_ready is 1 exactly when the transmit queue is not full. rx_data stays stable while rx_valid is high and rx_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock from the host |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| rx_data | output | 18 | Payload received from the host |
| rx_valid | output | 1 | rx_data holds a queued payload |
| rx_ready | input | 1 | Core accepts rx_data |
| tx_data | input | 18 | Payload to send to the host |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Transmit queue can take tx_data |

## Verification
A table of frames covers all four command codes. The transmit queue starts with two entries and the receive queue is never drained during the table. Because of this, each reply shows whether the head was popped, kept or replaced, and the receive flag falls exactly when the fourth write fills the queue. One write is sent into the full queue. The queue is then drained, which tells a discard apart from an overwrite of an earlier entry. A frame cut off at ten clocks, followed by a no-command frame, shows that nothing was consumed. Filling the transmit queue through the core stream exercises the tx_ready boundary.

// File: rtl/spi_rv_pkg.sv
package spi_rv_pkg;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WRITE = 2'b10,
        CMD_WRRD  = 2'b11
    } spi_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_SHIFT  = 2'b01,
        ST_COMMIT = 2'b10
    } frame_state_e;

endpackage

// File: rtl/spi_rv_sync.sv
module spi_rv_sync #(
    parameter int            WIDTH   = 3,
    parameter int            STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
            else        chain <= {chain[STAGES-2:0], async_i[b]};
        end
        assign sync_o[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/spi_rv_fifo.sv
module spi_rv_fifo #(
    parameter int W     = 18,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] data_i,
    input  logic         pop_i,
    output logic [W-1:0] data_o,
    output logic         full_o,
    output logic         empty_o
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign full_o  = (count == CW'(DEPTH));
    assign empty_o = (count == '0);
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;
    assign data_o  = mem[rd_ptr];

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wrap_inc(wr_ptr);
            if (do_pop)  rd_ptr <= wrap_inc(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= data_i;
    end

    // R7: a push while full must leave the occupancy in range
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R6: the frame engine only pops when an entry exists
    p_pop_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);

endmodule

// File: rtl/spi_rv_frame.sv
module spi_rv_frame
    import spi_rv_pkg::*;
#(
    parameter int FRAME_W = 20,
    localparam int PAY_W  = FRAME_W - 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_s,
    input  logic             cs_n_s,
    input  logic             mosi_s,
    input  logic             rx_space_i,
    input  logic             tx_avail_i,
    input  logic [PAY_W-1:0] tx_head_i,
    output logic             miso_o,
    output logic             push_rx_o,
    output logic [PAY_W-1:0] rx_pay_o,
    output logic             pop_tx_o
);

    localparam int CNT_W = $clog2(FRAME_W + 2);

    frame_state_e       state, state_nx;
    logic               sclk_q, cs_q;
    logic               sclk_rise, sclk_fall, cs_fall, cs_rise;
    logic [FRAME_W-1:0] tx_sr, rx_sr;
    logic [CNT_W-1:0]   bit_cnt;
    logic               avail_q;
    spi_cmd_e           cmd;

    assign sclk_rise = sclk_s && !sclk_q;
    assign sclk_fall = !sclk_s && sclk_q;
    assign cs_fall   = !cs_n_s && cs_q;
    assign cs_rise   = cs_n_s && !cs_q;
    assign cmd       = spi_cmd_e'(rx_sr[FRAME_W-1 -: 2]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
        end else begin
            sclk_q <= sclk_s;
            cs_q   <= cs_n_s;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (cs_fall) state_nx = ST_SHIFT;
            ST_SHIFT:  if (cs_rise) state_nx = (bit_cnt == CNT_W'(FRAME_W)) ? ST_COMMIT : ST_IDLE;
            ST_COMMIT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        push_rx_o = 1'b0;
        pop_tx_o  = 1'b0;
        miso_o    = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_SHIFT:  miso_o = tx_sr[FRAME_W-1];
            ST_COMMIT: begin
                push_rx_o = (cmd == CMD_WRITE) || (cmd == CMD_WRRD);
                pop_tx_o  = avail_q && ((cmd == CMD_READ) || (cmd == CMD_WRRD));
            end
            default:   ;
        endcase
    end
    assign rx_pay_o = rx_sr[PAY_W-1:0];

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr   <= '0;
            rx_sr   <= '0;
            bit_cnt <= '0;
            avail_q <= 1'b0;
        end else if (state == ST_IDLE && cs_fall) begin
            tx_sr   <= {rx_space_i, tx_avail_i, tx_avail_i ? tx_head_i : PAY_W'(0)};
            rx_sr   <= '0;
            bit_cnt <= '0;
            avail_q <= tx_avail_i;
        end else if (state == ST_SHIFT) begin
            if (sclk_rise) begin
                rx_sr <= {rx_sr[FRAME_W-2:0], mosi_s};
                if (bit_cnt != CNT_W'(FRAME_W + 1)) bit_cnt <= bit_cnt + CNT_W'(1);
            end
            if (sclk_fall) tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
        end
    end

    // R8: commit only after a frame of exactly FRAME_W clocks
    p_commit_full_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMMIT) |-> ($past(bit_cnt) == CNT_W'(FRAME_W)));

    // R3: the space flag leads the reply as seen at frame start
    p_hdr_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cs_fall) |=> (tx_sr[FRAME_W-1] == $past(rx_space_i)));

    // R2: miso holds its bit across rising sclk edges
    p_miso_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && $past(state) == ST_SHIFT && !sclk_fall) |=> $stable(tx_sr));

endmodule

// File: rtl/spi_rv_minion.sv
module spi_rv_minion #(
    parameter int FRAME_W   = 20,
    parameter int RXQ_DEPTH = 4,
    parameter int TXQ_DEPTH = 4,
    parameter int SYNC_STG  = 2,
    localparam int PAY_W    = FRAME_W - 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             cs_n,
    input  logic             mosi,
    output logic             miso,
    output logic [PAY_W-1:0] rx_data,
    output logic             rx_valid,
    input  logic             rx_ready,
    input  logic [PAY_W-1:0] tx_data,
    input  logic             tx_valid,
    output logic             tx_ready
);

    logic [2:0]       pins_s;
    logic             push_rx, pop_tx;
    logic [PAY_W-1:0] rx_pay, tx_head;
    logic             rxq_full, rxq_empty, txq_full, txq_empty;

    spi_rv_sync #(.WIDTH(3), .STAGES(SYNC_STG), .RST_VAL(3'b010)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sclk, cs_n, mosi}),
        .sync_o  (pins_s)
    );

    spi_rv_frame #(.FRAME_W(FRAME_W)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (pins_s[2]),
        .cs_n_s     (pins_s[1]),
        .mosi_s     (pins_s[0]),
        .rx_space_i (!rxq_full),
        .tx_avail_i (!txq_empty),
        .tx_head_i  (tx_head),
        .miso_o     (miso),
        .push_rx_o  (push_rx),
        .rx_pay_o   (rx_pay),
        .pop_tx_o   (pop_tx)
    );

    spi_rv_fifo #(.W(PAY_W), .DEPTH(RXQ_DEPTH)) u_rxq (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push_rx),
        .data_i  (rx_pay),
        .pop_i   (rx_valid && rx_ready),
        .data_o  (rx_data),
        .full_o  (rxq_full),
        .empty_o (rxq_empty)
    );

    spi_rv_fifo #(.W(PAY_W), .DEPTH(TXQ_DEPTH)) u_txq (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (tx_valid && tx_ready),
        .data_i  (tx_data),
        .pop_i   (pop_tx),
        .data_o  (tx_head),
        .full_o  (txq_full),
        .empty_o (txq_empty)
    );

    assign rx_valid = !rxq_empty;
    assign tx_ready = !txq_full;

    // R9: an offered payload is held until the core takes it
    p_rx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

endmodule

// File: tb/test_spi_rv_minion.sv
`timescale 1ns/1ps
module test_spi_rv_minion;

    localparam int HALF = 8;
    localparam logic [17:0] PA = 18'h2A5C3, PB = 18'h15A3C;
    localparam logic [17:0] W1 = 18'h3F001, W2 = 18'h0ABCD, W3 = 18'h1FFFF;
    localparam logic [17:0] W4 = 18'h20000, W5 = 18'h33333;
    localparam int NVEC = 8;
    // {command, payload sent, expected reply}
    localparam logic [39:0] VEC [NVEC] = '{
        {2'b00, 18'h01234, 2'b11, PA},
        {2'b10, W1,        2'b11, PA},
        {2'b01, 18'h00000, 2'b11, PA},
        {2'b11, W2,        2'b11, PB},
        {2'b01, 18'h00000, 2'b10, 18'h0},
        {2'b10, W3,        2'b10, 18'h0},
        {2'b10, W4,        2'b10, 18'h0},
        {2'b10, W5,        2'b00, 18'h0}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, miso;
    logic [17:0] rx_data, tx_data = '0;
    logic rx_valid, rx_ready = 1'b0, tx_valid = 1'b0, tx_ready;
    int n_run = 0, n_fail = 0;
    logic [19:0] reply;

    always #5 clk = ~clk;

    spi_rv_minion i_spi_rv_minion (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_frame(input logic [19:0] out, input int nbits, output logic [19:0] got);
        got = '0;
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < nbits; i++) begin
            mosi = out[19-i];
            wait_clk(HALF);
            sclk = 1'b1;
            got = {got[18:0], miso};
            wait_clk(HALF);
            sclk = 1'b0;
        end
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic tx_push(input logic [17:0] v);
        tx_data = v;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic rx_take(input logic [17:0] exp, input string req);
        chk({req, " valid"}, {31'd0, rx_valid}, 32'd1);
        chk({req, " data"}, {14'd0, rx_data}, {14'd0, exp});
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        wait_clk(4);
        // R1: reset state
        chk("R1 rx_valid", {31'd0, rx_valid}, 32'd0);
        chk("R1 tx_ready", {31'd0, tx_ready}, 32'd1);
        chk("R1 miso", {31'd0, miso}, 32'd0);
        rst_n = 1'b1;
        wait_clk(4);

        tx_push(PA);
        tx_push(PB);
        wait_clk(2);

        // R2 R3 R4 R5 R6: command table with no draining of the rx queue
        for (int v = 0; v < NVEC; v++) begin
            spi_frame(VEC[v][39:20], 20, reply);
            chk($sformatf("R2 R3 R4 R6 reply vec%0d", v), {12'd0, reply}, {12'd0, VEC[v][19:0]});
        end

        // R5 R7: four writes delivered in order, the fifth discarded
        rx_take(W1, "R5 first");
        rx_take(W2, "R5 second");
        rx_take(W3, "R7 third");
        rx_take(W4, "R7 fourth");
        chk("R7 drop", {31'd0, rx_valid}, 32'd0);

        // R8: a cut-off write+read frame changes nothing
        tx_push(18'h0C0DE);
        wait_clk(2);
        spi_frame({2'b11, 18'h2BEEF}, 10, reply);
        chk("R8 no push", {31'd0, rx_valid}, 32'd0);
        spi_frame({2'b00, 18'h0}, 20, reply);
        chk("R8 no pop", {12'd0, reply}, {12'd0, 2'b11, 18'h0C0DE});

        // R9: transmit queue boundary
        tx_push(18'h00011);
        tx_push(18'h00022);
        tx_push(18'h00033);
        chk("R9 full", {31'd0, tx_ready}, 32'd0);
        spi_frame({2'b01, 18'h0}, 20, reply);
        chk("R9 read head", {12'd0, reply}, {12'd0, 2'b11, 18'h0C0DE});
        chk("R9 space again", {31'd0, tx_ready}, 32'd1);
        spi_frame({2'b00, 18'h0}, 20, reply);
        chk("R6 next head", {12'd0, reply}, {12'd0, 2'b11, 18'h00011});

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule